// File: doc/BRIEF.md
# Command-Pointer Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). The bus is open-drain: the block reads both lines on plain inputs and pulls SDA low through an output-enable. It samples both lines with the system clock and finds START, repeated START and STOP conditions in the sampled data. It answers one of three 7-bit addresses, chosen by a 2-bit strap input, and holds a 16-entry register file of 8-bit registers.

When a received byte has its top bit set, the block treats it as a command. The low four bits of that byte become a stored register pointer, and the pointer keeps its value across transactions. A received byte with the top bit clear is data. Data bytes are written at the pointer plus a running offset, and that offset restarts at every START and at every command. Reads work the same way: the byte at the pointer comes first, then the following entries, with the index wrapping inside the 16-entry space.

This one scheme covers send byte, write byte, write word, block write, receive byte, read word, block read, plain writes and combined-format reads with a repeated START. The block also answers a read at the alert response address by returning its own address.

Top module: `cmd_ptr_slave`

## Requirements
- R1: The slave acknowledges its address, which is set by `addr_sel`: 00 gives 0x29, 01 gives 0x49, 10 gives 0x39, and 11 gives 0x49.
- R2: If the address byte names a different slave, the block does not acknowledge it. The rest of that transaction changes neither the registers nor the pointer.
- R3: A received byte with bit 7 set loads bits 3:0 into the register pointer. The pointer keeps its value until the next such byte. A read that follows, with no command in its transaction, returns the register at that pointer. After reset the pointer and every register are zero.
- R4: Every written byte is acknowledged. A byte with bit 7 clear is stored at pointer+n, where n counts the data bytes since the last START or command.
- R5: Read data goes out MSB first. The k-th byte of a read (k from 0) is the register at pointer+k. After the master NACKs, the slave releases SDA.
- R6: In a combined read (command, then repeated START, then read), the read returns the register named by the new command.
- R7: The pointer+offset index wraps modulo 16: a word written at pointer 15 goes to registers 15 and 0.
- R8: A read addressed to 0x0C (the alert response address) is acknowledged and returns {own address, 0}. A write to 0x0C is not acknowledged.
- R9: If a START or STOP arrives in the middle of a byte, the partial byte is dropped. Registers and pointer are left unchanged.
- R10: SDA drive changes only while SCL is low. SDA is released in idle and during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 2 | Strap for the address: 00 low, 01 floating, 10 high, 11 floating |
| sda_oe | output | 1 | When high, pulls SDA low |

## Verification
A wrong stored pointer or offset is not visible right away. It shows in the very next read, which returns the wrong register one byte time later (nine SCL periods). That read may be a later transaction, because the pointer outlives the transaction. A wrong state in the byte sequencer shows within the same byte: an ACK is missing or comes a bit late, or the read bits are shifted. An SDA edge that the bench sees while SCL is high exposes a sequencer that is out of step with the bus.

// File: rtl/cmd_ptr_slave.sv
module cmd_ptr_slave #(
  parameter logic [6:0] ADDR_LOW   = 7'h29,
  parameter logic [6:0] ADDR_FLOAT = 7'h49,
  parameter logic [6:0] ADDR_HIGH  = 7'h39,
  parameter logic [6:0] ALERT_ADDR = 7'h0C,
  parameter int PTR_W = 4,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << PTR_W;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WR, WACK, RD, MACK} st_t;

  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  wire  scl_s = scl_q[SYNC-1];
  wire  sda_s = sda_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_r   = scl_s & ~scl_p;
  wire scl_f   = ~scl_s & scl_p;

  logic [6:0] own_addr;
  always_comb
    case (addr_sel)
      2'b00:   own_addr = ADDR_LOW;
      2'b10:   own_addr = ADDR_HIGH;
      default: own_addr = ADDR_FLOAT;
    endcase

  st_t              state;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic [PTR_W-1:0] ptr, idx;
  logic             rw, ara, mack;
  logic [7:0]       regs [DEPTH];

  wire [PTR_W-1:0] loc = ptr + idx;
  wire [7:0] tx_byte = ara ? {own_addr, 1'b0} : regs[loc];
  wire addr_hit = (sh[7:1] == own_addr);
  wire ara_hit  = (sh[7:1] == ALERT_ADDR) & sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE; bitcnt <= '0; sh <= '0; ptr <= '0; idx <= '0;
      rw <= 1'b0; ara <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (start_c) begin
      state <= ADDR; bitcnt <= '0; idx <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= IDLE; bitcnt <= '0; sda_oe <= 1'b0;
    end else begin
      case (state)
        ADDR, WR: begin
          if (scl_r) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_f && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (state == ADDR) begin
              if (addr_hit || ara_hit) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                ara    <= ~addr_hit;
                state  <= AACK;
              end else begin
                state <= IDLE;
              end
            end else begin
              if (sh[7]) begin
                ptr <= sh[PTR_W-1:0];
                idx <= '0;
              end else begin
                regs[loc] <= sh;
                idx       <= idx + 1'b1;
              end
              sda_oe <= 1'b1;
              state  <= WACK;
            end
          end
        end
        AACK: if (scl_f) begin
          if (rw) begin
            sh     <= tx_byte;
            sda_oe <= ~tx_byte[7];
            bitcnt <= '0;
            state  <= RD;
          end else begin
            sda_oe <= 1'b0;
            state  <= WR;
          end
        end
        WACK: if (scl_f) begin
          sda_oe <= 1'b0;
          state  <= WR;
        end
        RD: begin
          if (scl_r) bitcnt <= bitcnt + 4'd1;
          else if (scl_f) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              idx    <= idx + 1'b1;
              state  <= MACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        MACK: begin
          if (scl_r) mack <= ~sda_s;
          else if (scl_f) begin
            if (mack) begin
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              bitcnt <= '0;
              state  <= RD;
            end else begin
              state <= IDLE;
            end
          end
        end
        default: ;
      endcase
    end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R5
  oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {AACK, WACK, RD}));

  // R3
  ptr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> ($past(state) == WR && $past(sh[7])));

  // R2
  aack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AACK) |-> (addr_hit || ara_hit));

  // R9
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

// File: tb/cmd_ptr_slave_bench.sv
module cmd_ptr_slave_bench;
  localparam int Q = 32;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sda_oe;
  wire  sda_line = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  cmd_ptr_slave u_cmd_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe));

  int errors = 0, checks = 0, hi_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] mregs [16];
  int mptr = 0, midx = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always @(negedge clk) begin
    if (scl && sda_oe !== prev_oe) hi_viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] own_of(input logic [1:0] s);
    case (s)
      2'b00: return 7'h29;
      2'b10: return 7'h39;
      default: return 7'h49;
    endcase
  endfunction

  task automatic q(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); m_low = 0; q(); scl = 1; q(); m_low = 1; q(); scl = 0; q(); midx = 0; endtask
  task automatic bstop(); m_low = 1; q(); scl = 1; q(); m_low = 0; q(); endtask
  task automatic wbit(input logic b); m_low = ~b; q(); scl = 1; q(); q(); scl = 0; q(); endtask
  task automatic rbit(output logic b); m_low = 0; q(); scl = 1; q(); b = sda_line; q(); scl = 0; q(); endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~ack);
  endtask

  task automatic m_wr(input logic [7:0] b);
    if (b[7]) begin mptr = b[3:0]; midx = 0; end
    else begin mregs[(mptr + midx) % 16] = b; midx++; end
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input logic stop_after,
                          output logic aack, output int nacks);
    logic ack;
    nacks = 0;
    bstart();
    wbyte({a, 1'b0}, aack);
    if (aack)
      for (int i = 0; i < n; i++) begin
        wbyte(wbuf[i], ack);
        if (!ack) nacks++;
        m_wr(wbuf[i]);
      end
    if (stop_after) bstop();
  endtask

  task automatic read_check(input logic [6:0] a, input int n, input string req);
    logic aack;
    logic [7:0] exp;
    bstart();
    wbyte({a, 1'b1}, aack);
    check({req, " addr ack"}, aack, 1);
    if (aack) begin
      for (int i = 0; i < n; i++) begin
        rbyte(rbuf[i], i < n - 1);
        if (a == 7'h0C) exp = {own_of(sel), 1'b0};
        else begin exp = mregs[(mptr + midx) % 16]; midx++; end
        check({req, " read data"}, rbuf[i], exp);
      end
      q();
      check("R5 SDA released after NACK", sda_line, 1);
    end
    bstop();
  endtask

  task automatic wr_ok(input int n, input logic stop_after, input string req);
    logic aack; int nk;
    do_write(own_of(sel), n, stop_after, aack, nk);
    check({req, " addr ack"}, aack, 1);
    check({req, " data NACKs"}, nk, 0);
  endtask

  initial begin
    logic aack; logic b; int nk, n;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
    repeat (5) @(negedge clk);
    check("R10 SDA released in reset", sda_line, 1);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R10 SDA released idle", sda_line, 1);

    read_check(own_of(sel), 1, "R3 reset pointer/regs");

    for (int s = 0; s < 4; s++) begin
      sel = s[1:0];
      do_write(own_of(sel), 0, 1, aack, nk);
      check("R1 address select ack", aack, 1);
    end
    sel = 2'b00;
    do_write(7'h49, 0, 1, aack, nk);
    check("R2 foreign address NACK", aack, 0);

    wbuf[0] = 8'h83; wbuf[1] = 8'h11; wbuf[2] = 8'h22; wbuf[3] = 8'h33;
    wr_ok(4, 1, "R4 block write");
    wbuf[0] = 8'h83;
    wr_ok(1, 0, "R6 command");
    read_check(own_of(sel), 3, "R6 combined read");
    read_check(own_of(sel), 1, "R3 pointer persists");

    wbuf[0] = 8'h8F; wbuf[1] = 8'h5A; wbuf[2] = 8'h6B;
    wr_ok(3, 1, "R7 wrap write");
    wr_ok(1, 0, "R7 command");
    read_check(own_of(sel), 2, "R7 wrap read");

    wbuf[0] = 8'h81; wbuf[1] = 8'h77;
    do_write(7'h50, 2, 1, aack, nk);
    check("R2 foreign write NACK", aack, 0);
    read_check(own_of(sel), 2, "R2 no effect");

    read_check(7'h0C, 1, "R8 alert read");
    do_write(7'h0C, 0, 1, aack, nk);
    check("R8 alert write NACK", aack, 0);

    bstart(); wbyte({own_of(sel), 1'b0}, aack);
    wbit(1); wbit(0); wbit(0); wbit(0);
    bstop();
    read_check(own_of(sel), 1, "R9 mid-byte STOP");
    bstart(); wbyte({own_of(sel), 1'b0}, aack);
    wbit(1); wbit(0); wbit(0);
    read_check(own_of(sel), 1, "R9 mid-byte START");

    for (int it = 0; it < 8; it++) begin
      wbuf[0] = 8'h80 | 8'($urandom_range(0, 15));
      n = $urandom_range(1, 4);
      for (int i = 1; i <= n; i++) wbuf[i] = 8'($urandom_range(0, 127));
      wr_ok(n + 1, 1, "R4 random write");
      wr_ok(1, 0, "R6 random command");
      read_check(own_of(sel), n, "R5 random read");
    end

    check("R10 SDA changes while SCL high", hi_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule